// File: doc/BRIEF.md
# Warp Lane-Group Issue Sequencer

This block issues the instructions of one 32-thread warp onto a bank of 8 identical ALU lanes. The bank is four times narrower than the warp, so the sequencer splits each instruction into four lane groups and feeds one group per clock into a fixed-depth execution pipeline. Groups enter in thread order: threads 0-7 first, then 8-15, 16-23 and 24-31. The next instruction is accepted only after all four groups of the current one have entered, so instructions never interleave inside a warp.

An upstream scheduler presents an instruction with a valid/ready handshake. The instruction carries a 3-bit opcode, two 32-bit operands per thread and a 32-bit active-thread mask. Everything is captured in the accepting clock. Each group produces one write-back beat: per lane, a write enable, the thread index of that lane and the 32-bit result. An instruction always takes four issue slots, even when few or no threads are active. Masked-off threads use their slot but never raise a write enable.

Top module: `warpIssueSeq`

## Requirements
- R1: `inReady` is high exactly when no instruction is partly issued. After an instruction is accepted (`inValid && inReady` at a rising edge), `inReady` is low for the next three clocks and high again in the fourth.
- R2: An instruction accepted at edge t has its lane groups enter the pipeline at edges t, t+1, t+2 and t+3, in thread order. Group g drives write-back after edge t+4+g, for one clock only.
- R3: During a write-back beat, lane l of group g reports thread index 8*g + l in its 5-bit field of `wbTid` (bits 5l+4..5l).
- R4: Thread i raises a write enable only if bit i of the mask captured at acceptance is 1. Mask changes at the input after acceptance have no effect.
- R5: The result follows the opcode: 0 = a+b, 1 = a-b (modulo 2^32), 2 = a AND b, 3 = a OR b, 4 = a XOR b, 5 = a. Codes 6 and 7 behave like 5.
- R6: An instruction with a sparse or all-zero mask still holds the issue port for four clocks, and it writes back no inactive thread.
- R7: Operands and opcode are captured in the accepting clock. Input changes during groups 1-3 do not alter the results.
- R8: With `inValid` held high, a new instruction is accepted every fourth clock. The write-back of its group 0 follows directly after group 3 of the previous instruction.
- R9: A synchronous active-high `rst` empties the pipeline, returns the sequencer to group 0 (`inReady` high) and clears every write enable in the clock after the reset edge, even when an instruction is in flight.
- R10: While `inValid` is low and nothing is in flight, no write enable is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Group 0 of a new instruction can enter this clock |
| inOp | input | 3 | ALU opcode |
| inMask | input | 32 | Active-thread mask, bit i = thread i |
| inOpA | input | 1024 | Operand A, thread i in bits 32i+31..32i |
| inOpB | input | 1024 | Operand B, same layout |
| wbValid | output | 8 | Per-lane write enable |
| wbTid | output | 40 | Per-lane thread index, 5 bits per lane |
| wbData | output | 256 | Per-lane result, 32 bits per lane |

## Verification
In back-to-back operation, the acceptance of a new instruction (operand capture and group 0 entry) falls in the same clock edge that releases group 0 of the previous instruction from the pipeline tail. The bench provokes this by holding `inValid` high and changing operands and masks every clock. Its per-cycle model expects both the new capture and the old write-back beat. Any mix-up between the captured copy and the live inputs appears as a data, thread-index or enable mismatch on a lane.

// File: rtl/warpSeqPkg.sv
package warpSeqPkg;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_OR   = 3'd3;
  localparam logic [2:0] OP_XOR  = 3'd4;
  localparam logic [2:0] OP_PASS = 3'd5;

  // Strobes from the group sequencer to the datapath
  typedef struct packed {
    logic takeNew;  // instruction accepted, group 0 enters from the inputs
    logic issue;    // some lane group enters the pipeline this clock
  } issueCtl_t;

endpackage

// File: rtl/warpAluLane.sv
module warpAluLane
  import warpSeqPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_ADD:  res = opA + opB;
      OP_SUB:  res = opA - opB;
      OP_AND:  res = opA & opB;
      OP_OR:   res = opA | opB;
      OP_XOR:  res = opA ^ opB;
      default: res = opA;
    endcase
  end

endmodule

// File: rtl/warpIssueCtrl.sv
module warpIssueCtrl
  import warpSeqPkg::*;
#(
  parameter int GROUPS = 4,
  localparam int GRP_W = $clog2(GROUPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  output logic [GRP_W-1:0] grp,
  output issueCtl_t        ctl
);

  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);

  logic [GRP_W-1:0] grpCnt;

  assign inReady     = (grpCnt == '0);
  assign ctl.takeNew = inValid && inReady;
  assign ctl.issue   = ctl.takeNew || (grpCnt != '0);
  assign grp         = grpCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      grpCnt <= '0;
    end else if (ctl.issue) begin
      grpCnt <= (grpCnt == LAST_GRP) ? '0 : grpCnt + 1'b1;
    end
  end

endmodule

// File: rtl/warpIssueData.sv
module warpIssueData
  import warpSeqPkg::*;
#(
  parameter int WARP_SIZE  = 32,
  parameter int LANES      = 8,
  parameter int DATA_W     = 32,
  parameter int PIPE_DEPTH = 4,
  localparam int GROUPS = WARP_SIZE / LANES,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int LANE_W = $clog2(LANES),
  localparam int TID_W  = $clog2(WARP_SIZE)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  issueCtl_t                   ctl,
  input  logic [GRP_W-1:0]            grp,
  input  logic [2:0]                  inOp,
  input  logic [WARP_SIZE-1:0]        inMask,
  input  logic [WARP_SIZE*DATA_W-1:0] inOpA,
  input  logic [WARP_SIZE*DATA_W-1:0] inOpB,
  output logic [LANES-1:0]            wbValid,
  output logic [LANES*TID_W-1:0]      wbTid,
  output logic [LANES*DATA_W-1:0]     wbData
);

  // Copy of the instruction held for groups 1..GROUPS-1
  logic [2:0]                  hOp;
  logic [WARP_SIZE-1:0]        hMask;
  logic [WARP_SIZE*DATA_W-1:0] hA, hB;

  always_ff @(posedge clk) begin
    if (ctl.takeNew) begin
      hOp   <= inOp;
      hMask <= inMask;
      hA    <= inOpA;
      hB    <= inOpB;
    end
  end

  // Group 0 reads the live inputs, later groups the held copy
  logic [2:0]                  curOp;
  logic [WARP_SIZE-1:0]        curMask;
  logic [WARP_SIZE*DATA_W-1:0] curA, curB;
  logic [TID_W-1:0]            baseTid;

  assign curOp   = ctl.takeNew ? inOp   : hOp;
  assign curMask = ctl.takeNew ? inMask : hMask;
  assign curA    = ctl.takeNew ? inOpA  : hA;
  assign curB    = ctl.takeNew ? inOpB  : hB;
  assign baseTid = {grp, {LANE_W{1'b0}}};

  // Entry stage: one lane group per clock
  logic                 s0Valid;
  logic [2:0]           s0Op;
  logic [GRP_W-1:0]     s0Grp;
  logic [LANES-1:0]     s0Mask;
  logic [DATA_W-1:0]    s0A [LANES];
  logic [DATA_W-1:0]    s0B [LANES];

  always_ff @(posedge clk) begin
    if (rst) s0Valid <= 1'b0;
    else     s0Valid <= ctl.issue;
  end

  always_ff @(posedge clk) begin
    if (ctl.issue) begin
      s0Op   <= curOp;
      s0Grp  <= grp;
      s0Mask <= curMask[baseTid +: LANES];
      for (int l = 0; l < LANES; l++) begin
        s0A[l] <= curA[(int'(baseTid) + l)*DATA_W +: DATA_W];
        s0B[l] <= curB[(int'(baseTid) + l)*DATA_W +: DATA_W];
      end
    end
  end

  logic [DATA_W-1:0] aluRes [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    warpAluLane #(.DATA_W(DATA_W)) u_lane (
      .op  (s0Op),
      .opA (s0A[l]),
      .opB (s0B[l]),
      .res (aluRes[l])
    );
  end

  // Result stages 1..PIPE_DEPTH; the last one drives write-back
  logic [PIPE_DEPTH:1] pValid;
  logic [GRP_W-1:0]    pGrp  [1:PIPE_DEPTH];
  logic [LANES-1:0]    pMask [1:PIPE_DEPTH];
  logic [DATA_W-1:0]   pData [1:PIPE_DEPTH][LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      pValid <= '0;
    end else begin
      pValid[1] <= s0Valid;
      for (int k = 2; k <= PIPE_DEPTH; k++) pValid[k] <= pValid[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pGrp[1]  <= s0Grp;
    pMask[1] <= s0Mask;
    pData[1] <= aluRes;
    for (int k = 2; k <= PIPE_DEPTH; k++) begin
      pGrp[k]  <= pGrp[k-1];
      pMask[k] <= pMask[k-1];
      pData[k] <= pData[k-1];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_wb
    assign wbValid[l]                     = pValid[PIPE_DEPTH] & pMask[PIPE_DEPTH][l];
    assign wbTid[l*TID_W +: TID_W]        = {pGrp[PIPE_DEPTH], LANE_W'(l)};
    assign wbData[l*DATA_W +: DATA_W]     = pData[PIPE_DEPTH][l];
  end

endmodule

// File: rtl/warpIssueSeq.sv
module warpIssueSeq
  import warpSeqPkg::*;
#(
  parameter int WARP_SIZE  = 32,  // power of two, multiple of LANES
  parameter int LANES      = 8,   // power of two
  parameter int DATA_W     = 32,
  parameter int PIPE_DEPTH = 4,   // at least 2
  localparam int GROUPS = WARP_SIZE / LANES,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int TID_W  = $clog2(WARP_SIZE)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [2:0]                  inOp,
  input  logic [WARP_SIZE-1:0]        inMask,
  input  logic [WARP_SIZE*DATA_W-1:0] inOpA,
  input  logic [WARP_SIZE*DATA_W-1:0] inOpB,
  output logic [LANES-1:0]            wbValid,
  output logic [LANES*TID_W-1:0]      wbTid,
  output logic [LANES*DATA_W-1:0]     wbData
);

  issueCtl_t        ctl;
  logic [GRP_W-1:0] grp;

  warpIssueCtrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .grp     (grp),
    .ctl     (ctl)
  );

  warpIssueData #(
    .WARP_SIZE  (WARP_SIZE),
    .LANES      (LANES),
    .DATA_W     (DATA_W),
    .PIPE_DEPTH (PIPE_DEPTH)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .grp     (grp),
    .inOp    (inOp),
    .inMask  (inMask),
    .inOpA   (inOpA),
    .inOpB   (inOpB),
    .wbValid (wbValid),
    .wbTid   (wbTid),
    .wbData  (wbData)
  );

endmodule

// File: rtl/warpIssueSeqChk.sv
module warpIssueSeqChk #(
  parameter int WARP_SIZE = 32,
  parameter int LANES     = 8,
  localparam int TID_W  = $clog2(WARP_SIZE),
  localparam int LANE_W = $clog2(LANES)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   inValid,
  input logic                   inReady,
  input logic [LANES-1:0]       wbValid,
  input logic [LANES*TID_W-1:0] wbTid
);

  // R1: after acceptance the port is closed for three clocks, then reopens
  p_ready_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady ##1 !inReady ##1 !inReady ##1 inReady);

  // R1: the port only closes because an instruction was taken
  p_fall_on_accept_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(inReady) |-> $past(inValid));

  // R3: a writing lane reports its own lane number in the low index bits
  for (genvar l = 0; l < LANES; l++) begin : g_tid
    p_tid_lane_r3: assert property (@(posedge clk) disable iff (rst)
      wbValid[l] |-> (wbTid[l*TID_W +: LANE_W] == LANE_W'(l)));
  end

  // R9: a reset edge leaves no write enable and an open port
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (wbValid == '0) && inReady);

endmodule

bind warpIssueSeq warpIssueSeqChk #(
  .WARP_SIZE (WARP_SIZE),
  .LANES     (LANES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inReady (inReady),
  .wbValid (wbValid),
  .wbTid   (wbTid)
);

// File: tb/warpIssueSeq_tb.sv
module warpIssueSeq_tb;

  localparam int WS = 32;
  localparam int NL = 8;
  localparam int DW = 32;
  localparam int TW = 5;
  localparam int RING = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [2:0]       inOp = '0;
  logic [WS-1:0]    inMask = '0;
  logic [WS*DW-1:0] inOpA = '0;
  logic [WS*DW-1:0] inOpB = '0;
  logic [NL-1:0]    wbValid;
  logic [NL*TW-1:0] wbTid;
  logic [NL*DW-1:0] wbData;

  warpIssueSeq u_dut (
    .clk (clk), .rst (rst), .inValid (inValid), .inReady (inReady),
    .inOp (inOp), .inMask (inMask), .inOpA (inOpA), .inOpB (inOpB),
    .wbValid (wbValid), .wbTid (wbTid), .wbData (wbData)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int busyLeft = 0;
  bit done = 1'b0;

  logic [NL-1:0] expV [RING];
  int            expBase [RING];
  logic [DW-1:0] expD [RING][NL];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] refAlu(input logic [2:0] op, input logic [DW-1:0] a, b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return a;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic clearRing();
    for (int s = 0; s < RING; s++) begin
      expV[s] = '0;
      expBase[s] = 0;
      for (int l = 0; l < NL; l++) expD[s][l] = '0;
    end
  endtask

  // Compare the write-back port against the model slot of this cycle
  task automatic checkWb();
    int s = cyc % RING;
    check("R2/R4/R10 write enables", 64'(wbValid), 64'(expV[s]));
    for (int l = 0; l < NL; l++) begin
      if (expV[s][l] && wbValid[l]) begin
        check("R3 thread index", 64'(wbTid[l*TW +: TW]), 64'(expBase[s] + l));
        check("R5/R7 result", 64'(wbData[l*DW +: DW]), 64'(expD[s][l]));
      end
    end
    expV[s] = '0;
  endtask

  // One clock: called at a falling edge, returns at the next falling edge
  task automatic step(input bit v, input logic [2:0] op, input logic [WS-1:0] m);
    bit readyNow;
    bit fire;
    checkWb();
    readyNow = (busyLeft == 0);
    check("R1/R6 ready", 64'(inReady), 64'(readyNow));
    if (!readyNow) busyLeft--;
    inValid = v;
    inOp    = op;
    inMask  = m;
    for (int t = 0; t < WS; t++) begin
      inOpA[t*DW +: DW] = $urandom;
      inOpB[t*DW +: DW] = (t % 5 == 0) ? inOpA[t*DW +: DW] : $urandom;
    end
    fire = v && readyNow;
    if (fire) begin
      busyLeft = 3;
      for (int g = 0; g < 4; g++) begin
        int s = (cyc + 5 + g) % RING;
        expBase[s] = 8*g;
        for (int l = 0; l < NL; l++) begin
          expV[s][l] = m[8*g + l];
          expD[s][l] = refAlu(op, inOpA[(8*g+l)*DW +: DW], inOpB[(8*g+l)*DW +: DW]);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'($urandom), $urandom);
  endtask

  task automatic issueOne(input logic [2:0] op, input logic [WS-1:0] m);
    step(1'b1, op, m);
    // inputs keep changing while groups 1-3 issue (R7, R4)
    for (int i = 0; i < 3; i++) step(1'b0, 3'($urandom), $urandom);
  endtask

  initial begin
    clearRing();
    repeat (3) @(negedge clk);
    // R9: state right after reset
    check("R9 reset wbValid", 64'(wbValid), 64'd0);
    check("R9 reset ready", 64'(inReady), 64'd1);
    rst = 1'b0;

    idle(6);  // R10: nothing offered, nothing written

    for (int op = 0; op < 8; op++) issueOne(3'(op), 32'hFFFF_FFFF);  // R5 all opcodes
    issueOne(3'd0, 32'h0000_0001);  // R6 single thread
    issueOne(3'd4, 32'h0000_0000);  // R6 empty mask
    issueOne(3'd1, 32'h8000_0000);  // R4 last thread only
    issueOne(3'd3, 32'h00FF_00FF);  // R4 alternate groups
    idle(8);

    // R8: back-to-back stream
    for (int i = 0; i < 200; i++) step(1'b1, 3'($urandom % 6), $urandom);
    // random offering
    for (int i = 0; i < 300; i++) step(($urandom % 3) != 0, 3'($urandom), $urandom);

    // R9: reset with an instruction in flight
    step(1'b1, 3'd0, 32'hFFFF_FFFF);
    step(1'b1, 3'd0, 32'hFFFF_FFFF);
    checkWb();
    rst = 1'b1;
    inValid = 1'b0;
    clearRing();
    busyLeft = 0;
    @(negedge clk);
    check("R9 mid-flight wbValid", 64'(wbValid), 64'd0);
    check("R9 mid-flight ready", 64'(inReady), 64'd1);
    rst = 1'b0;
    idle(6);

    for (int i = 0; i < 60; i++) step(1'b1, 3'($urandom), $urandom);
    idle(10);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule